// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called A and B, and can move data in either direction. Each direction has its own capture register with its own clock. The register samples its source bus on every rising clock edge. Per-direction selects decide whether a driving port carries the live value of the opposite bus or that direction's stored word. Per-direction enables decide which ports drive at all.

Each port appears as three signals: the sampled bus value, a drive value and a drive enable. The pad or tri-state resolution lives outside the block. When both directions drive live data and nothing else drives either bus, the cross-coupled drive keeps both buses at their last value.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both stored words to zero. After reset, a port set to drive stored data drives 0.
- R2: On every rising edge of `clk_ab_i`, the A-to-B register loads `a_in_i`, whatever the selects and enables are.
- R3: On every rising edge of `clk_ba_i`, the B-to-A register loads `b_in_i`, whatever the selects and enables are.
- R4: `b_oe_o` is 1 exactly when `en_ab_i` is 1 (active high).
- R5: `a_oe_o` is 1 exactly when `en_ba_ni` is 0 (active low).
- R6: With `en_ab_i`=0 and `en_ba_ni`=1, neither port drives (isolation).
- R7: `b_out_o` equals `a_in_i` when `sel_ab_i`=0 and equals the stored A-to-B word when `sel_ab_i`=1.
- R8: `a_out_o` equals `b_in_i` when `sel_ba_i`=0 and equals the stored B-to-A word when `sel_ba_i`=1.
- R9: With both ports driving live data (`en_ab_i`=1, `en_ba_ni`=0, both selects 0), both buses keep their last value after every other driver releases them.
- R10: When B drives live A data and `clk_ba_i` rises, the B-to-A register captures that driven value, so one value can be held in both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ab_i | input | 1 | B-port drive enable, active high |
| en_ba_ni | input | 1 | A-port drive enable, active low |
| sel_ab_i | input | 1 | B drive source: 0 live A, 1 stored |
| sel_ba_i | input | 1 | A drive source: 0 live B, 1 stored |
| a_in_i | input | W | Sampled value of bus A |
| a_out_o | output | W | Value to place on bus A |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_in_i | input | W | Sampled value of bus B |
| b_out_o | output | W | Value to place on bus B |
| b_oe_o | output | 1 | Drive enable for bus B |

## Verification
The assertions assume that selects, enables and sampled bus values are stable around each rising capture-clock edge. They also assume that the external bus never has two active drivers at once. The stimulus changes every input only while the bench clock is low. It gates the two capture clocks from that clock, and it enables an external bus driver only on a port whose own drive enable is off. A bench resolver settles the buses and keeps the last value on any undriven bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;

  function automatic logic drive_on(input logic pin, input logic act_high);
    return (pin == act_high);
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] q_o
);
  // unconditional capture: no enable of any kind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= src_i;
  end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int W            = 8,
  parameter bit EN_ACT_HIGH  = 1'b1
) (
  input  logic         sel_i,
  input  logic         en_pin_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] drv_o,
  output logic         oe_o
);
  src_sel_e src;

  always_comb begin
    src   = src_sel_e'(sel_i);
    drv_o = (src == SRC_HELD) ? held_i : live_i;
    oe_o  = drive_on(en_pin_i, EN_ACT_HIGH);
  end
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W = 8
) (
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         rst_ni,
  input  logic         en_ab_i,
  input  logic         en_ba_ni,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_in_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o
);
  localparam int NDIR = 2;   // index 0: A to B, index 1: B to A

  logic [NDIR-1:0]   dir_clk, dir_sel, dir_en, dir_oe;
  logic [W-1:0]      dir_src [NDIR];
  logic [W-1:0]      dir_q   [NDIR];
  logic [W-1:0]      dir_drv [NDIR];

  // named internal words for the checker
  logic [W-1:0] held_ab, held_ba;

  assign dir_clk = {clk_ba_i, clk_ab_i};
  assign dir_sel = {sel_ba_i, sel_ab_i};
  assign dir_en  = {en_ba_ni, en_ab_i};
  assign dir_src[0] = a_in_i;
  assign dir_src[1] = b_in_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_store #(.W(W)) u_store (
      .clk_i  (dir_clk[d]),
      .rst_ni (rst_ni),
      .src_i  (dir_src[d]),
      .q_o    (dir_q[d])
    );
    xcvr_route #(.W(W), .EN_ACT_HIGH(d == 0)) u_route (
      .sel_i    (dir_sel[d]),
      .en_pin_i (dir_en[d]),
      .live_i   (dir_src[d]),
      .held_i   (dir_q[d]),
      .drv_o    (dir_drv[d]),
      .oe_o     (dir_oe[d])
    );
  end

  assign held_ab = dir_q[0];
  assign held_ba = dir_q[1];
  assign b_out_o = dir_drv[0];
  assign b_oe_o  = dir_oe[0];
  assign a_out_o = dir_drv[1];
  assign a_oe_o  = dir_oe[1];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk_ab_i,
  input logic         clk_ba_i,
  input logic         rst_ni,
  input logic         en_ab_i,
  input logic         en_ba_ni,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_in_i,
  input logic [W-1:0] b_in_i,
  input logic [W-1:0] a_out_o,
  input logic [W-1:0] b_out_o,
  input logic         a_oe_o,
  input logic         b_oe_o,
  input logic [W-1:0] held_ab,
  input logic [W-1:0] held_ba
);
  p_cap_ab_r2: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    1'b1 |=> (held_ab == $past(a_in_i)));

  p_cap_ba_r3: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    1'b1 |=> (held_ba == $past(b_in_i)));

  p_isolate_r6: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!en_ab_i && en_ba_ni) |-> (!a_oe_o && !b_oe_o));

  p_live_b_r7: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !sel_ab_i |-> (b_out_o == a_in_i));

  p_held_b_r7: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    sel_ab_i |-> (b_out_o == held_ab));

  p_held_a_r8: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    sel_ba_i |-> (a_out_o == held_ba));

  p_live_a_r8: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !sel_ba_i |-> (a_out_o == b_in_i));
endmodule

bind bidir_reg_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk_ab_i (clk_ab_i), .clk_ba_i (clk_ba_i), .rst_ni (rst_ni),
  .en_ab_i  (en_ab_i),  .en_ba_ni (en_ba_ni),
  .sel_ab_i (sel_ab_i), .sel_ba_i (sel_ba_i),
  .a_in_i   (a_in_i),   .b_in_i   (b_in_i),
  .a_out_o  (a_out_o),  .b_out_o  (b_out_o),
  .a_oe_o   (a_oe_o),   .b_oe_o   (b_oe_o),
  .held_ab  (held_ab),  .held_ba  (held_ba)
);

// File: tb/tb_bidir_reg_xcvr.sv
`timescale 1ns/1ps
module tb_bidir_reg_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic gate_ab = 1'b0, gate_ba = 1'b0;
  logic clk_ab, clk_ba;
  assign clk_ab = clk & gate_ab;
  assign clk_ba = clk & gate_ba;

  logic rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_bus = '0, b_bus = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  logic ext_a_on = 1'b0, ext_b_on = 1'b0;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  int checks = 0, failures = 0;

  bidir_reg_xcvr #(.W(W)) dut (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .en_ab_i(en_ab), .en_ba_ni(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_in_i(a_bus), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_bus), .b_out_o(b_out), .b_oe_o(b_oe)
  );

  function automatic logic [W-1:0] want(input logic use_held,
                                        input logic [W-1:0] live,
                                        input logic [W-1:0] held);
    if (use_held) return held;
    return live;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus resolver: external driver, else block driver, else weak hold
  task automatic settle();
    for (int i = 0; i < 3; i++) begin
      a_bus = ext_a_on ? ext_a : (a_oe ? a_out : a_bus);
      b_bus = ext_b_on ? ext_b : (b_oe ? b_out : b_bus);
      #1;
    end
  endtask

  task automatic step(input logic eab, input logic ebn, input logic sab,
                      input logic sba, input logic xa, input logic [W-1:0] va,
                      input logic xb, input logic [W-1:0] vb,
                      input logic cab, input logic cba);
    @(negedge clk);
    gate_ab = 1'b0; gate_ba = 1'b0;
    en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    ext_a_on = xa; ext_a = va; ext_b_on = xb; ext_b = vb;
    settle();
    gate_ab = cab; gate_ba = cba;
    @(posedge clk);
    if (cab) m_ab = a_bus;
    if (cba) m_ba = b_bus;
    @(negedge clk);
    gate_ab = 1'b0; gate_ba = 1'b0;
    settle();
  endtask

  task automatic check_all();
    chk(b_oe === en_ab, "R4 b_oe", {7'd0, b_oe}, {7'd0, en_ab});
    chk(a_oe === !en_ba_n, "R5 a_oe", {7'd0, a_oe}, {7'd0, !en_ba_n});
    chk(b_out === want(sel_ab, a_bus, m_ab), "R7 b_out (R2 store)",
        b_out, want(sel_ab, a_bus, m_ab));
    chk(a_out === want(sel_ba, b_bus, m_ba), "R8 a_out (R3 store)",
        a_out, want(sel_ba, b_bus, m_ba));
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0707));
    ext_a_on = 1'b1; ext_a = 8'h3C; ext_b_on = 1'b1; ext_b = 8'hA5;
    settle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen through stored selection
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk(b_out === 8'h00, "R1 b_out after reset", b_out, 8'h00);
    chk(a_out === 8'h00, "R1 a_out after reset", a_out, 8'h00);

    // R6: isolation
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11, 1'b1, 8'h22, 1'b0, 1'b0);
    chk(!a_oe && !b_oe, "R6 isolation", {6'd0, a_oe, b_oe}, 8'h00);

    // R2/R3: capture while isolated and in stored mode
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 8'hC4, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk(b_out === 8'h5A, "R2 stored A word", b_out, 8'h5A);
    chk(a_out === 8'hC4, "R3 stored B word", a_out, 8'hC4);

    // R9: cross-coupled live drive holds 0x96 after release
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h96, 1'b1, 8'h96, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk(a_bus === 8'h96, "R9 hold A", a_bus, 8'h96);
    chk(b_bus === 8'h96, "R9 hold B", b_bus, 8'h96);

    // R10: A input 0xE7 driven live onto B, both registers clocked
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE7, 1'b0, '0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk(a_out === 8'hE7, "R10 B-to-A holds A value", a_out, 8'hE7);
    chk(b_out === 8'hE7, "R10 A-to-B holds A value", b_out, 8'hE7);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic eab, ebn, xa, xb;
      eab = 1'($urandom);
      ebn = 1'($urandom);
      xa  = ebn ? 1'($urandom) : 1'b0;
      xb  = eab ? 1'b0 : 1'($urandom);
      step(eab, ebn, 1'($urandom), 1'($urandom),
           xa, W'($urandom), xb, W'($urandom), 1'($urandom), 1'($urandom));
      check_all();
      if (!eab && ebn)
        chk(!a_oe && !b_oe, "R6 random isolation", {6'd0, a_oe, b_oe}, 8'h00);
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0; m_ab = '0; m_ba = '0;
    #2 rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    chk(b_out === 8'h00, "R1 async clear A-to-B", b_out, 8'h00);
    chk(a_out === 8'h00, "R1 async clear B-to-A", a_out, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule